// File: doc/BRIEF.md
# Wake-Up Source Controller with Dual Debounce

This block gathers the wake-up causes of a low-power domain and merges them into one request that brings the core power supply back up. It runs entirely on the slow clock. Three internal causes (a supply-monitor detection, a real-time-timer alarm and a real-time-clock alarm) each have an enable bit. Two active-high wake-up pins reach the merge point through two separate debounce paths. The first path counts slow-clock cycles against a selectable period. The second, low-power path counts rising edges of a real-time-clock output tick.

When the low-power path qualifies a pin, it can also emit a one-cycle pulse that wipes the lower half of a bank of backup registers. A mode word is presented in parallel and captured into an internal mode register on a load strobe. The wake request is sticky. It stays asserted until the power manager acknowledges it.

Top module: `wkup_ctrl`

## Requirements
- R1: After reset the mode register holds all zeros: every cause is disabled, the pin period is immediate and the low-power path is off. With no mode load, wake_o and clear_o stay low whatever the inputs do.
- R2: Mode bits 0, 1 and 2 enable the supply-monitor, timer-alarm and clock-alarm causes. With its bit at 1, a cause that is high before a clock edge sets wake_o at that edge. With its bit at 0, the cause has no effect.
- R3: Once set, wake_o holds until ack_i is seen high at an edge, and it then falls at that edge. If a qualified cause is present in the same cycle, wake_o stays high.
- R4: Each pin passes through a two-flop synchronizer. Mode bits 4:3 enable pin 1 and pin 0 on the slow-clock path. With period code 0 (immediate), a pin raised before edge 1 sets wake_o at edge 3.
- R5: The pin period code in mode bits 7:5 sets the required run of consecutive high samples: 1→3, 2→32, 3→512, 4→4096, 5→32768. A pin raised before edge 1 sets wake_o at edge N+2.
- R6: Pin period codes 6 and 7 act as 32768.
- R7: A pin sample at 0 restarts both debounce counts, so the high time must be unbroken.
- R8: The low-power period code in mode bits 13:11 counts rising edges of tick_i seen on the slow clock. Codes 1 to 7 need 2 to 8 edges while the pin stays high. Code 0 disables the path.
- R9: Mode bits 9:8 admit pin 1 and pin 0 to the low-power path. A pin whose bit is 0 never qualifies there.
- R10: With mode bit 10 set, the start of a low-power qualification on either pin gives a clear_o pulse one cycle wide. With the bit clear, no pulse is produced.
- R11: A low-power qualification also sets wake_o, in the same cycle as its clear pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_ld_i | input | 1 | Captures mode_i into the mode register |
| mode_i | input | 14 | Mode word (bit layout given in R2, R4, R5, R8, R9, R10) |
| supmon_i | input | 1 | Supply-monitor detection |
| rtt_alarm_i | input | 1 | Real-time-timer alarm |
| rtc_alarm_i | input | 1 | Real-time-clock alarm |
| pin_i | input | 2 | Asynchronous wake-up pins, active high |
| tick_i | input | 1 | Real-time-clock output tick |
| ack_i | input | 1 | Acknowledge that clears the wake request |
| wake_o | output | 1 | Sticky wake-up request |
| clear_o | output | 1 | One-cycle clear for the lower backup registers |

## Verification
The hardest case to reach is the longest pin period. Its run of 32768 unbroken samples must meet its threshold exactly, and the reserved codes must reach the same count. The stimulus sets code 6 and holds a pin steady for the whole run. It checks the output one edge before and one edge after the expected cycle. A second hard case is a broken run on both paths. A one-cycle low glitch is driven partway through a count, and the late arrival of the wake proves that the count restarted. On the low-power path, the tick is toggled while a pin is enabled there and while it is not, so that clear pulses and wakes can be counted against the mode bits.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
   localparam int PIN_CNT_W = 16;
   localparam int LP_CNT_W  = 4;
   localparam int CODE_W    = 3;

   // run length needed on the slow-clock path; reserved codes take the longest
   function automatic logic [PIN_CNT_W:0] pin_limit(input logic [CODE_W-1:0] code);
      logic [PIN_CNT_W:0] lim;
      case (code)
         3'd0:    lim = 17'd1;
         3'd1:    lim = 17'd3;
         3'd2:    lim = 17'd32;
         3'd3:    lim = 17'd512;
         3'd4:    lim = 17'd4096;
         default: lim = 17'd32768;
      endcase
      return lim;
   endfunction

   // tick edges needed on the low-power path (code 0 handled as disabled)
   function automatic logic [LP_CNT_W-1:0] lp_limit(input logic [CODE_W-1:0] code);
      return LP_CNT_W'(code) + LP_CNT_W'(1);
   endfunction
endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   initial begin
      if (STAGES < 2) $error("wkup_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wkup_pin_dbnc.sv
module wkup_pin_dbnc
   import wkup_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              lvl_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              hit_o
);
   localparam logic [PIN_CNT_W-1:0] SAT = PIN_CNT_W'(32768);

   logic [PIN_CNT_W-1:0] run_q;
   logic [PIN_CNT_W:0]   run_inc;

   assign run_inc = {1'b0, run_q} + 17'd1;
   assign hit_o   = lvl_i && (run_inc >= pin_limit(code_i));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           run_q <= '0;
      else if (!lvl_i)       run_q <= '0;
      else if (run_q != SAT) run_q <= run_inc[PIN_CNT_W-1:0];
   end

   // any period above one sample implies the pin was already high
   assert_hold_continuous_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_o && code_i != '0) |-> $past(lvl_i));
endmodule

// File: rtl/wkup_lp_dbnc.sv
module wkup_lp_dbnc
   import wkup_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              lvl_i,
   input  logic              edge_i,
   input  logic              en_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              hit_o
);
   localparam logic [LP_CNT_W-1:0] SAT = LP_CNT_W'(8);

   logic [LP_CNT_W-1:0] ticks_q;

   assign hit_o = en_i && (code_i != '0) && lvl_i && (ticks_q >= lp_limit(code_i));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        ticks_q <= '0;
      else if (!lvl_i)                    ticks_q <= '0;
      else if (edge_i && ticks_q != SAT)  ticks_q <= ticks_q + LP_CNT_W'(1);
   end

   // at least two counted edges mean the pin was high a cycle earlier
   assert_lp_needs_history_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o |-> $past(lvl_i));
endmodule

// File: rtl/wkup_ctrl.sv
module wkup_ctrl
   import wkup_pkg::*;
#(
   parameter int NUM_PINS    = 2,
   parameter int SYNC_STAGES = 2,
   parameter int MODE_W      = 10 + 2*NUM_PINS
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                mode_ld_i,
   input  logic [MODE_W-1:0]   mode_i,
   input  logic                supmon_i,
   input  logic                rtt_alarm_i,
   input  logic                rtc_alarm_i,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic                tick_i,
   input  logic                ack_i,
   output logic                wake_o,
   output logic                clear_o
);
   localparam int B_PIN_EN  = 3;
   localparam int B_PCODE   = B_PIN_EN + NUM_PINS;
   localparam int B_LP_EN   = B_PCODE + CODE_W;
   localparam int B_CLR     = B_LP_EN + NUM_PINS;
   localparam int B_LPCODE  = B_CLR + 1;

   initial begin
      if (NUM_PINS < 1) $error("wkup_ctrl: NUM_PINS must be at least 1");
      if (MODE_W != B_LPCODE + CODE_W) $error("wkup_ctrl: MODE_W inconsistent");
   end

   logic [MODE_W-1:0]   mode_q;
   logic [NUM_PINS-1:0] pin_s, pin_hit, lp_hit;
   logic                tick_q, tick_edge;
   logic                lp_any, lp_any_q, set_any;
   logic                wake_q, clear_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        mode_q <= '0;
      else if (mode_ld_i) mode_q <= mode_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tick_q <= 1'b0;
      else         tick_q <= tick_i;
   end
   assign tick_edge = tick_i && !tick_q;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      wkup_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk_i (clk_i), .rst_ni(rst_ni), .d_i(pin_i[p]), .q_o(pin_s[p]));

      logic pin_raw;
      wkup_pin_dbnc u_pin (
         .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(pin_s[p]),
         .code_i(mode_q[B_PCODE +: CODE_W]), .hit_o(pin_raw));
      assign pin_hit[p] = pin_raw && mode_q[B_PIN_EN + p];

      wkup_lp_dbnc u_lp (
         .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(pin_s[p]), .edge_i(tick_edge),
         .en_i  (mode_q[B_LP_EN + p]), .code_i(mode_q[B_LPCODE +: CODE_W]),
         .hit_o (lp_hit[p]));
   end

   assign lp_any  = |lp_hit;
   assign set_any = (supmon_i    && mode_q[0]) ||
                    (rtt_alarm_i && mode_q[1]) ||
                    (rtc_alarm_i && mode_q[2]) ||
                    (|pin_hit) || lp_any;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wake_q   <= 1'b0;
         clear_q  <= 1'b0;
         lp_any_q <= 1'b0;
      end else begin
         wake_q   <= (wake_q && !ack_i) || set_any;
         clear_q  <= mode_q[B_CLR] && lp_any && !lp_any_q;
         lp_any_q <= lp_any;
      end
   end

   assign wake_o  = wake_q;
   assign clear_o = clear_q;

   assert_wake_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wake_o && !ack_i) |=> wake_o);
   assert_ack_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && !set_any) |=> !wake_o);
   assert_clear_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_o |=> !clear_o);
   assert_clear_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_o |-> $past(mode_q[B_CLR]));
   assert_clear_wakes_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_o |-> wake_o);
endmodule

// File: tb/wkup_ctrl_tb.sv
module wkup_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_ld = 1'b0;
   logic [13:0] mode = '0;
   logic        supmon = 1'b0, rtt = 1'b0, rtc = 1'b0, tick = 1'b0, ack = 1'b0;
   logic [1:0]  pin = '0;
   logic        wake, clr;

   int checks = 0, fails = 0, cycles = 0, clr_seen = 0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   wkup_ctrl u_dut (
      .clk_i(clk), .rst_ni(rst_n), .mode_ld_i(mode_ld), .mode_i(mode),
      .supmon_i(supmon), .rtt_alarm_i(rtt), .rtc_alarm_i(rtc), .pin_i(pin),
      .tick_i(tick), .ack_i(ack), .wake_o(wake), .clear_o(clr));

   // behavioural reference model
   logic [13:0] m_mode;
   int m_s1[2], m_s2[2], m_run[2], m_tk[2];
   bit m_wake, m_clr, m_lp_prev, m_tick_prev;

   function automatic int pin_need(int code);
      case (code)
         0: return 1;  1: return 3;  2: return 32;
         3: return 512; 4: return 4096; default: return 32768;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = '0; m_wake = 0; m_clr = 0; m_lp_prev = 0; m_tick_prev = 0;
         foreach (m_s1[i]) begin m_s1[i] = 0; m_s2[i] = 0; m_run[i] = 0; m_tk[i] = 0; end
      end else begin
         bit set, lp, edge_seen;
         int pc, lc;
         pc = int'(m_mode[7:5]);
         lc = int'(m_mode[13:11]);
         set = (supmon && m_mode[0]) || (rtt && m_mode[1]) || (rtc && m_mode[2]);
         lp = 0;
         for (int p = 0; p < 2; p++) begin
            if (m_mode[3+p] && m_s2[p] != 0 && m_run[p] + 1 >= pin_need(pc)) set = 1;
            if (lc != 0 && m_mode[8+p] && m_s2[p] != 0 && m_tk[p] >= lc + 1) lp = 1;
         end
         if (lp) set = 1;
         m_wake = (m_wake && !ack) || set;
         m_clr = m_mode[10] && lp && !m_lp_prev;
         m_lp_prev = lp;
         edge_seen = tick && !m_tick_prev;
         m_tick_prev = tick;
         for (int p = 0; p < 2; p++) begin
            if (m_s2[p] == 0) begin m_run[p] = 0; m_tk[p] = 0; end
            else begin
               if (m_run[p] < 32768) m_run[p]++;
               if (edge_seen && m_tk[p] < 8) m_tk[p]++;
            end
            m_s2[p] = m_s1[p];
            m_s1[p] = int'(pin[p]);
         end
         if (mode_ld) m_mode = mode;
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         checks++;
         if (wake !== m_wake || clr !== m_clr) begin
            fails++;
            $display("FAIL %s model: wake=%0b clr=%0b expected wake=%0b clr=%0b",
                     cur_req, wake, clr, m_wake, m_clr);
         end
         if (clr === 1'b1) clr_seen++;
      end
      if (cycles > 190000) begin
         fails++;
         $display("FAIL watchdog: cycles=%0d expected below 190000", cycles);
         summary();
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_bit(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic load(logic [13:0] m);
      mode = m; mode_ld = 1'b1; step(1); mode_ld = 1'b0;
   endtask

   task automatic quiet();
      supmon = 0; rtt = 0; rtc = 0; pin = '0; tick = 0;
      step(4); ack = 1'b1; step(1); ack = 1'b0; step(1);
   endtask

   // pin run of N samples: wake at edge N+2 after the drive
   task automatic pin_period(string req, int p, logic [13:0] m, int need);
      quiet(); load(m); step(1);
      pin[p] = 1'b1;
      step(need + 1); expect_bit(req, wake, 1'b0);
      step(1);        expect_bit(req, wake, 1'b1);
   endtask

   initial begin
      step(3); rst_n = 1'b1; step(1);

      // R1: reset state, no mode load
      cur_req = "R1";
      expect_bit("R1", wake, 1'b0);
      supmon = 1; rtt = 1; rtc = 1; pin = 2'b11;
      for (int i = 0; i < 40; i++) begin tick = ~tick; step(1); end
      expect_bit("R1", wake, 1'b0);
      expect_bit("R1", clr, 1'b0);

      // R2: each internal cause, enabled and disabled
      cur_req = "R2";
      for (int s = 0; s < 3; s++) begin
         quiet(); load(14'd1 << s); step(1);
         supmon = (s != 0); rtt = (s != 1); rtc = (s != 2); // only others high
         step(3); expect_bit("R2", wake, 1'b0);
         supmon = (s == 0); rtt = (s == 1); rtc = (s == 2);
         step(1); expect_bit("R2", wake, 1'b1);
         // R3: holds without ack, released by ack once the cause drops
         cur_req = "R3";
         supmon = 0; rtt = 0; rtc = 0;
         step(5); expect_bit("R3", wake, 1'b1);
         ack = 1; step(1); ack = 0; expect_bit("R3", wake, 1'b0);
         cur_req = "R2";
      end
      // R3: ack overridden by a present cause
      cur_req = "R3";
      quiet(); load(14'h001); step(1); supmon = 1; step(2);
      ack = 1; step(1); ack = 0; expect_bit("R3", wake, 1'b1);

      // R4: immediate code through the synchronizer
      cur_req = "R4";
      pin_period("R4", 0, 14'h0008, 1);
      // R5: table entries
      cur_req = "R5";
      pin_period("R5", 1, 14'h0010 | (14'd1 << 5), 3);
      pin_period("R5", 0, 14'h0008 | (14'd2 << 5), 32);
      pin_period("R5", 1, 14'h0010 | (14'd3 << 5), 512);
      // R6: reserved code behaves as the longest period
      cur_req = "R6";
      pin_period("R6", 0, 14'h0008 | (14'd6 << 5), 32768);

      // R7: a glitch low restarts the slow-clock count
      cur_req = "R7";
      quiet(); load(14'h0008 | (14'd2 << 5)); step(1);
      pin[0] = 1; step(20); pin[0] = 0; step(1); pin[0] = 1;
      step(33); expect_bit("R7", wake, 1'b0);
      step(1);  expect_bit("R7", wake, 1'b1);

      // R8/R11: low-power path, code 3 needs 4 tick edges
      cur_req = "R8";
      quiet(); clr_seen = 0; load(14'h0100 | (14'd3 << 11)); step(1);
      pin[0] = 1; step(3);
      for (int i = 0; i < 10; i++) begin tick = 1; step(2); tick = 0; step(2); end
      expect_bit("R11", wake, 1'b1);
      expect_bit("R10", clr_seen != 0, 1'b0);
      // R7 on the low-power path: glitch restarts edge count
      cur_req = "R7";
      quiet(); load(14'h0100 | (14'd7 << 11)); step(1);
      pin[0] = 1; step(3);
      for (int i = 0; i < 5; i++) begin tick = 1; step(2); tick = 0; step(2); end
      pin[0] = 0; step(1); pin[0] = 1; step(3);
      for (int i = 0; i < 5; i++) begin tick = 1; step(2); tick = 0; step(2); end
      expect_bit("R7", wake, 1'b0);
      // R8: code 0 disables the low-power path
      cur_req = "R8";
      quiet(); load(14'h0300); step(1);
      pin = 2'b11; step(3);
      for (int i = 0; i < 12; i++) begin tick = 1; step(2); tick = 0; step(2); end
      expect_bit("R8", wake, 1'b0);
      // R9: pin 0 not admitted when only pin 1 is enabled
      cur_req = "R9";
      quiet(); load(14'h0200 | 14'h0400 | (14'd1 << 11)); step(1); clr_seen = 0;
      pin[0] = 1; step(3);
      for (int i = 0; i < 12; i++) begin tick = 1; step(2); tick = 0; step(2); end
      expect_bit("R9", wake, 1'b0);
      expect_bit("R9", clr_seen != 0, 1'b0);
      // R10: clear enabled gives exactly one pulse
      cur_req = "R10";
      pin[1] = 1; step(3);
      for (int i = 0; i < 12; i++) begin tick = 1; step(2); tick = 0; step(2); end
      expect_bit("R10", clr_seen == 1, 1'b1);
      expect_bit("R11", wake, 1'b1);

      step(5);
      summary();
   end
endmodule